// File: doc/BRIEF.md
# Pulse-Width Lock Detector

This block watches the up and down pulses that a phase-frequency detector sends to its charge pump, and tells the rest of the synthesizer whether the loop has settled. It runs on the reference clock and samples both pump pulses on every rising edge. A pulse that is still high on two successive edges is wider than one reference period and is treated as long. Anything narrower is treated as short.

The reference divider's terminal-count strobe marks the end of each comparison cycle. A cycle is clean if no long pulse appeared in it. Once enough clean cycles have come in a row (fifteen by default), the lock-detect output goes high. A single long pulse drops the output and restarts the run on the very edge where the pulse is seen, without waiting for the cycle to end. The output is an ordinary registered logic level, so no analog filter is needed downstream. A power-down input clears all state.

Top module: `pw_lock_detect`

## Requirements
- R1: While `rst_n` is low at a rising edge of `ref_clk`, the run count is cleared, and `lock_det` is low after that edge.
- R2: A pump pulse seen high at only one rising edge, then low at the next, is short and does not disturb the run of clean cycles.
- R3: When `pump_up` or `pump_dn` is high at two successive rising edges, the pulse is long, and `lock_det` is low after the second of those edges.
- R4: A long pulse resets the run to zero, so relock needs a full new series of `LOCK_COUNT` clean cycles after the cycle that held the long pulse.
- R5: A comparison cycle ends at each rising edge where `cmp_strobe` is high. The cycle counts as clean only if no long pulse was detected in it, including at the closing edge itself.
- R6: `lock_det` rises at the strobe edge that closes the `LOCK_COUNT`-th consecutive clean cycle, and not one cycle earlier.
- R7: The run count saturates at `LOCK_COUNT`. Further clean cycles keep `lock_det` high.
- R8: `pwr_dn` high at a rising edge clears the run, the pulse measurement and the open-cycle flag. `lock_det` is low after that edge, and a strobe at that edge is not counted.
- R9: A pump pulse that stays high for many edges holds `lock_det` low and the run at zero on every edge after its second.
- R10: Up and down pulses are treated alike. The width is measured on their OR, so a pulse that hands over from up to down without a low gap is still one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Power-down; clears all state while high |
| pump_up | input | 1 | Up pulse from the phase detector, synchronous to `ref_clk` |
| pump_dn | input | 1 | Down pulse from the phase detector, synchronous to `ref_clk` |
| cmp_strobe | input | 1 | Reference divider terminal count; one cycle high per comparison cycle |
| lock_det | output | 1 | Registered lock indication |

## Verification
The bench builds the block with its defaults: a run of fifteen clean cycles and a long-pulse threshold of two edges. Short comparison cycles of three to five reference periods let it walk several full runs, step across the fourteen/fifteen boundary, and overrun the saturation point, all well within the cycle budget. With the two-edge threshold, single-edge pulses, pulses that hand over from up to down, long pulses that land on the strobe edge and power-down during a strobe all come within reach of the directed cases and of the biased random phase.

// File: rtl/pwld_pkg.sv
// Package: shared types and helpers for the pulse-width lock detector.
// Assumes nothing beyond the parameters handed to its functions.
package pwld_pkg;

    // Verdict that the window qualifier hands to the lock counter each edge.
    typedef enum logic [1:0] {
        VERDICT_NONE = 2'd0,   // no decision at this edge
        VERDICT_GOOD = 2'd1,   // a clean comparison cycle closed here
        VERDICT_FAIL = 2'd2    // a long pulse was seen, or a dirty cycle closed
    } verdict_t;

    // Width needed to hold values 0..n inclusive, never below one bit.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pwld_pulse_meter.sv
// Module: pwld_pulse_meter
// Measures how many consecutive reference edges the combined pump pulse
// (up OR down) has been high, and flags a long pulse at the edge where the
// pulse has been high for LONG_EDGES successive samples, and at every later
// edge while it stays high.
// Assumes pump_up and pump_dn are already synchronous to clk.
module pwld_pulse_meter #(
    parameter int LONG_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn,
    input  logic pump_up,
    input  logic pump_dn,
    output logic long_hit
);

    localparam int RUN_MAX = LONG_EDGES - 1;
    localparam int RUN_W   = (LONG_EDGES > 2) ? $clog2(LONG_EDGES) : 1;
    localparam logic [RUN_W-1:0] RUN_LIM = RUN_W'(RUN_MAX);

    logic             pump_any;
    logic             at_limit;
    logic [RUN_W-1:0] run_q;

    // Combine the two pulses and decide whether this sample makes the pulse long.
    always_comb begin
        pump_any = pump_up | pump_dn;
        at_limit = (run_q == RUN_LIM);
        long_hit = pump_any & at_limit;
    end

    // Count consecutive high samples, saturating one below the long threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            run_q <= '0;
        end else if (!pump_any) begin
            run_q <= '0;
        end else if (!at_limit) begin
            run_q <= run_q + 1'b1;
        end
    end

    // R9: the run register never passes its saturation value.
    a_r9_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_LIM);

    // R3 / R10: with a threshold of two or more edges, a long flag needs the
    // combined pulse to have been high on the previous edge as well.
    generate
        if (LONG_EDGES >= 2) begin : g_history_check
            a_r3_long_needs_history: assert property (@(posedge clk) disable iff (!rst_n)
                long_hit |-> $past(pump_up | pump_dn));
        end
    endgenerate

endmodule

// File: rtl/pwld_window_qual.sv
// Module: pwld_window_qual
// Tracks whether a long pulse has occurred inside the open comparison cycle,
// and turns that into a verdict for the lock counter: FAIL on the edge where
// a long pulse is seen, GOOD when the strobe closes a clean cycle, FAIL when
// it closes a dirty one, NONE otherwise.
// Assumes cmp_strobe is a single-cycle pulse synchronous to clk.
module pwld_window_qual
    import pwld_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pwr_dn,
    input  logic     cmp_strobe,
    input  logic     long_hit,
    output verdict_t verdict
);

    logic bad_q;

    // Produce this edge's verdict from the live long flag and the cycle history.
    always_comb begin
        if (long_hit) begin
            verdict = VERDICT_FAIL;
        end else if (cmp_strobe) begin
            verdict = bad_q ? VERDICT_FAIL : VERDICT_GOOD;
        end else begin
            verdict = VERDICT_NONE;
        end
    end

    // Remember a long pulse until the strobe opens a fresh cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            bad_q <= 1'b0;
        end else if (cmp_strobe) begin
            bad_q <= 1'b0;
        end else if (long_hit) begin
            bad_q <= 1'b1;
        end
    end

    // R5: a GOOD verdict never comes out of a cycle that held a long pulse.
    a_r5_good_only_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (verdict == VERDICT_GOOD) |-> (!bad_q && !long_hit));

endmodule

// File: rtl/pwld_lock_counter.sv
// Module: pwld_lock_counter
// Counts consecutive clean comparison cycles up to LOCK_COUNT and drives the
// registered lock indication. A FAIL verdict or power-down clears the count.
// Assumes verdicts come from pwld_window_qual on the same clock.
module pwld_lock_counter
    import pwld_pkg::*;
#(
    parameter int LOCK_COUNT = 15
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pwr_dn,
    input  verdict_t verdict,
    output logic     lock_det
);

    localparam int unsigned CNT_W = cnt_width(LOCK_COUNT);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LOCK_COUNT);
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(LOCK_COUNT - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ld_q;

    // Advance, clear or hold the clean-cycle run and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            cnt_q <= '0;
            ld_q  <= 1'b0;
        end else begin
            unique case (verdict)
                VERDICT_FAIL: begin
                    cnt_q <= '0;
                    ld_q  <= 1'b0;
                end
                VERDICT_GOOD: begin
                    if (cnt_q != CNT_MAX) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                    ld_q <= (cnt_q >= CNT_PRE);
                end
                default: begin
                    cnt_q <= cnt_q;
                    ld_q  <= ld_q;
                end
            endcase
        end
    end

    assign lock_det = ld_q;

    // R7: the run count never exceeds its saturation value.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R6: lock is high only while a full run has been recorded.
    a_r6_lock_means_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        ld_q |-> (cnt_q == CNT_MAX));

    // R6: lock can only rise on an edge that closed a clean cycle.
    a_r6_rise_on_good: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ld_q) |-> $past(verdict == VERDICT_GOOD));

endmodule

// File: rtl/pw_lock_detect.sv
// Module: pw_lock_detect (top)
// Digital lock detector: declares lock after LOCK_COUNT consecutive comparison
// cycles free of pump pulses at least LONG_EDGES reference edges wide, and
// drops lock on the edge where any such pulse is seen.
// Assumes all inputs are synchronous to ref_clk and cmp_strobe is one cycle wide.
module pw_lock_detect
    import pwld_pkg::*;
#(
    parameter int LOCK_COUNT = 15,
    parameter int LONG_EDGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic pwr_dn,
    input  logic pump_up,
    input  logic pump_dn,
    input  logic cmp_strobe,
    output logic lock_det
);

    logic     long_hit;
    verdict_t verdict;

    pwld_pulse_meter #(
        .LONG_EDGES (LONG_EDGES)
    ) u_meter (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .long_hit (long_hit)
    );

    pwld_window_qual u_qual (
        .clk        (ref_clk),
        .rst_n      (rst_n),
        .pwr_dn     (pwr_dn),
        .cmp_strobe (cmp_strobe),
        .long_hit   (long_hit),
        .verdict    (verdict)
    );

    pwld_lock_counter #(
        .LOCK_COUNT (LOCK_COUNT)
    ) u_count (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .pwr_dn   (pwr_dn),
        .verdict  (verdict),
        .lock_det (lock_det)
    );

    // R3: a long pulse from the meter drops lock on the next output value.
    a_r3_long_drops_lock: assert property (@(posedge ref_clk) disable iff (!rst_n)
        long_hit |=> !lock_det);

    // R8: power-down forces the output low after the edge.
    a_r8_pwr_dn_clears: assert property (@(posedge ref_clk) disable iff (!rst_n)
        pwr_dn |=> !lock_det);

    // R4: with no strobe, lock cannot appear out of nowhere.
    a_r4_no_rise_without_strobe: assert property (@(posedge ref_clk) disable iff (!rst_n)
        !cmp_strobe |=> !$rose(lock_det));

endmodule

// File: tb/tb_pw_lock_detect.sv
`timescale 1ns/1ps
module tb_pw_lock_detect;

    localparam int LOCK_COUNT = 15;
    localparam int LONG_EDGES = 2;

    logic ref_clk    = 1'b0;
    logic rst_n      = 1'b0;
    logic pwr_dn     = 1'b0;
    logic pump_up    = 1'b0;
    logic pump_dn    = 1'b0;
    logic cmp_strobe = 1'b0;
    logic lock_det;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // expected-state model built from the requirements
    int m_run = 0;
    int m_cnt = 0;
    bit m_bad = 1'b0;
    bit m_ld  = 1'b0;

    always #2.5 ref_clk = ~ref_clk;

    pw_lock_detect #(
        .LOCK_COUNT (LOCK_COUNT),
        .LONG_EDGES (LONG_EDGES)
    ) dut (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .pwr_dn     (pwr_dn),
        .pump_up    (pump_up),
        .pump_dn    (pump_dn),
        .cmp_strobe (cmp_strobe),
        .lock_det   (lock_det)
    );

    // Expected lock after one edge with the given inputs.
    function automatic void model_step(input bit up, input bit dn, input bit stb,
                                       input bit pd, input bit rs);
        bit p;
        bit lng;
        if (!rs || pd) begin
            m_run = 0; m_bad = 1'b0; m_cnt = 0; m_ld = 1'b0;
            return;
        end
        p   = up | dn;
        lng = p && (m_run >= LONG_EDGES - 1);
        if (!p) m_run = 0;
        else if (m_run < LONG_EDGES - 1) m_run = m_run + 1;
        if (lng) begin
            m_cnt = 0; m_ld = 1'b0;
        end else if (stb && !m_bad) begin
            if (m_cnt < LOCK_COUNT) m_cnt = m_cnt + 1;
            m_ld = (m_cnt == LOCK_COUNT);
        end else if (stb) begin
            m_cnt = 0; m_ld = 1'b0;
        end
        m_bad = stb ? 1'b0 : (m_bad | lng);
    endfunction

    // Drive one edge's inputs at the falling edge, then check after the rising edge.
    task automatic cycle(input bit up, input bit dn, input bit stb, input bit pd,
                         input bit rs, input string req);
        pump_up = up; pump_dn = dn; cmp_strobe = stb; pwr_dn = pd; rst_n = rs;
        model_step(up, dn, stb, pd, rs);
        @(posedge ref_clk);
        @(negedge ref_clk);
        checks++;
        if (lock_det !== m_ld) begin
            errors++;
            $display("FAIL %s lock_det=%0b expected=%0b at %0t", req, lock_det, m_ld, $time);
        end
    endtask

    // One clean comparison cycle: a single-edge pulse, idle, then the strobe.
    task automatic clean_window(input int len, input bit use_dn, input string req);
        cycle(!use_dn, use_dn, 1'b0, 1'b0, 1'b1, req);
        for (int i = 0; i < len - 2; i++) cycle(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, req);
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, req);
    endtask

    initial begin
        // watchdog
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog lock_det=%0b expected=done", lock_det);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge ref_clk);
        // R1: reset state, even with pulses and strobes present
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R1");

        // R2 / R5 / R6: fourteen clean cycles leave the output low
        for (int w = 0; w < LOCK_COUNT - 1; w++) clean_window(3 + (w % 3), w[0], "R2");
        checks++;
        if (lock_det !== 1'b0) begin
            errors++;
            $display("FAIL R6 lock_det=%0b expected=0 after 14 clean cycles", lock_det);
        end
        clean_window(4, 1'b0, "R6");
        checks++;
        if (lock_det !== 1'b1) begin
            errors++;
            $display("FAIL R6 lock_det=%0b expected=1 after 15 clean cycles", lock_det);
        end

        // R7: saturation keeps the lock
        for (int w = 0; w < 6; w++) clean_window(3, 1'b1, "R7");

        // R3 / R10: up handing over to down without a gap is one long pulse
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R10");
        cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R3");
        checks++;
        if (lock_det !== 1'b0) begin
            errors++;
            $display("FAIL R3 lock_det=%0b expected=0 after long pulse", lock_det);
        end
        // R9: pulse held high for many edges
        for (int i = 0; i < 6; i++) cycle(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R9");
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R5");

        // R4: full relock needs a whole new run
        for (int w = 0; w < LOCK_COUNT - 1; w++) clean_window(3, 1'b0, "R4");
        clean_window(3, 1'b0, "R4");

        // R5: long pulse ending on the strobe edge spoils that cycle
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R5");
        cycle(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R5");
        for (int w = 0; w < LOCK_COUNT; w++) clean_window(4, 1'b1, "R5");

        // R8: power-down with a strobe present clears everything
        cycle(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
        cycle(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R8");
        cycle(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, "R8");
        for (int w = 0; w < LOCK_COUNT; w++) clean_window(3, 1'b0, "R8");

        // random phase: mostly clean traffic with occasional long pulses
        for (int i = 0; i < 4000; i++) begin
            bit up, dn, stb, pd;
            up  = ($urandom_range(0, 99) < 12);
            dn  = ($urandom_range(0, 99) < 12);
            if ((i % 40) >= 4 && !((i % 40) < 10 && i > 2000)) begin
                if (($urandom_range(0, 99) < 80)) begin up = 1'b0; dn = 1'b0; end
            end
            stb = ((i % 4) == 3);
            pd  = ($urandom_range(0, 999) < 3);
            cycle(up, dn, stb, pd, 1'b1, "R5");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule